// File: doc/BRIEF.md
# Burst Address Load and Advance Unit

This block forms the address path of a synchronous burst memory. On every rising clock edge it does one of three things: it captures a fresh external address, it steps an internal two-bit beat counter, or it holds its state. A capture can come from either of two active-low address strobes. One strobe comes from a cache controller and is always honoured. The other comes from a processor and only counts while the active-low chip enable is asserted. Stepping is requested with an active-low advance input.

The output is the full memory address. Its upper bits are the captured address, unchanged. Its low two bits are generated from the captured low bits and the beat counter. A quasi-static order-select input picks the pattern. In linear order the starting bits are added to the counter modulo four. In interleaved order the starting bits are XORed with the counter. A burst always wraps inside its aligned four-word block. The order input is meant to stay fixed for the whole time the memory is operating.

Top module: `burst_addr_unit`

## Requirements
- R1: When `strobe_cache_n` is 0 at a rising edge, the address is captured whatever `chip_en_n` is, and `mem_addr` equals that `addr_in` after the edge.
- R2: `strobe_proc_n` = 0 captures the address only when `chip_en_n` = 0 at the same edge. With `chip_en_n` = 1 it has no effect on `mem_addr`.
- R3: With no capture and `advance_n` = 1, `mem_addr` keeps its value across the edge.
- R4: With no capture and `advance_n` = 0, the beat counter steps by one, modulo 4.
- R5: With `order_sel` = 0 (linear), the low two bits of `mem_addr` are (start + beat) mod 4, so a start of 1 gives 1, 2, 3, 0.
- R6: With `order_sel` = 1 (interleaved), the low two bits are start XOR beat, so starts 1, 2 and 3 give 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R7: After four steps the sequence wraps to the start value. `mem_addr[17:2]` never changes without a capture.
- R8: A capture and an advance at the same edge perform the capture only. The beat counter restarts at zero, so `mem_addr` equals the new `addr_in`.
- R9: While `rst_n` is 0, `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 18 | External address, captured on a strobe |
| strobe_cache_n | input | 1 | Cache-controller address strobe, active low |
| strobe_proc_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Burst advance request, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| mem_addr | output | 18 | Memory address with burst-generated low bits |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The address register and the beat counter are the only state, and `mem_addr` is decoded from them without further registers. The driver task changes inputs on the falling edge. After the following rising edge it queues the value the requirements predict. The monitor pops that value and compares it with `mem_addr` at the next falling edge, so each check samples half a period after the edge that made the result.

// File: rtl/bau_pkg.sv
package bau_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;

  localparam int unsigned DEF_ADDR_W  = 18;
  localparam int unsigned DEF_BURST_W = 2;
endpackage

// File: rtl/bau_load_decode.sv
module bau_load_decode (
  input  logic strobe_cache_n,
  input  logic strobe_proc_n,
  input  logic chip_en_n,
  input  logic advance_n,
  output logic load_evt,
  output logic step_evt
);
  logic cache_req;
  logic proc_req;

  always_comb begin
    cache_req = ~strobe_cache_n;
    proc_req  = ~strobe_proc_n & ~chip_en_n;
    load_evt  = cache_req | proc_req;
    step_evt  = ~load_evt & ~advance_n;
  end
endmodule

// File: rtl/bau_addr_reg.sv
module bau_addr_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (load_evt) base_q <= addr_in;
  end
endmodule

// File: rtl/bau_beat_counter.sv
module bau_beat_counter #(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic               step_evt,
  output logic [BURST_W-1:0] beat_q
);
  localparam logic [BURST_W-1:0] BEAT_ONE = BURST_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (step_evt) beat_q <= beat_q + BEAT_ONE;
  end
endmodule

// File: rtl/bau_order_map.sv
module bau_order_map #(
  parameter int unsigned BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_bits,
  input  logic [BURST_W-1:0] beat,
  input  logic               order_sel,
  output logic [BURST_W-1:0] low_bits
);
  import bau_pkg::*;

  function automatic logic [BURST_W-1:0] linear_step(
    input logic [BURST_W-1:0] s, input logic [BURST_W-1:0] b);
    return s + b;
  endfunction

  function automatic logic [BURST_W-1:0] interleave_step(
    input logic [BURST_W-1:0] s, input logic [BURST_W-1:0] b);
    return s ^ b;
  endfunction

  burst_order_e mode;

  always_comb begin
    mode = burst_order_e'(order_sel);
    case (mode)
      ORDER_INTERLEAVED: low_bits = interleave_step(start_bits, beat);
      default:           low_bits = linear_step(start_bits, beat);
    endcase
  end
endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit #(
  parameter int unsigned ADDR_W  = bau_pkg::DEF_ADDR_W,
  parameter int unsigned BURST_W = bau_pkg::DEF_BURST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cache_n,
  input  logic              strobe_proc_n,
  input  logic              chip_en_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int unsigned UPPER_W = ADDR_W - BURST_W;

  logic               load_evt;
  logic               step_evt;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_cnt;
  logic [BURST_W-1:0] low_bits;
  logic [UPPER_W-1:0] upper_bits;

  bau_load_decode u_decode (
    .strobe_cache_n (strobe_cache_n),
    .strobe_proc_n  (strobe_proc_n),
    .chip_en_n      (chip_en_n),
    .advance_n      (advance_n),
    .load_evt       (load_evt),
    .step_evt       (step_evt)
  );

  bau_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .addr_in  (addr_in),
    .base_q   (base_q)
  );

  bau_beat_counter #(.BURST_W(BURST_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat_q   (beat_cnt)
  );

  bau_order_map #(.BURST_W(BURST_W)) u_order (
    .start_bits (base_q[BURST_W-1:0]),
    .beat       (beat_cnt),
    .order_sel  (order_sel),
    .low_bits   (low_bits)
  );

  assign upper_bits = base_q[ADDR_W-1:BURST_W];
  assign mem_addr   = {upper_bits, low_bits};
endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  addr_in,
  input logic               strobe_cache_n,
  input logic               strobe_proc_n,
  input logic               chip_en_n,
  input logic               advance_n,
  input logic               order_sel,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [BURST_W-1:0] beat_cnt
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  logic no_cap;
  assign no_cap = strobe_cache_n & (strobe_proc_n | chip_en_n);

  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (mem_addr == '0); // R9
  end

  AST_CACHE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_cache_n |=> mem_addr == $past(addr_in)); // R1
  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cache_n && !strobe_proc_n && chip_en_n && advance_n) |=> $stable(mem_addr)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_cap && advance_n) |=> $stable(mem_addr)); // R3
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_cap && !advance_n) |=> beat_cnt == $past(beat_cnt) + ONE); // R4
  AST_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (no_cap && !advance_n && !order_sel) |=>
      mem_addr[BURST_W-1:0] == $past(mem_addr[BURST_W-1:0]) + ONE); // R5
  AST_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (no_cap && !advance_n && order_sel) |=>
      (mem_addr[BURST_W-1:0] ^ $past(mem_addr[BURST_W-1:0])) == (beat_cnt ^ $past(beat_cnt))); // R6
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    no_cap |=> mem_addr[ADDR_W-1:BURST_W] == $past(mem_addr[ADDR_W-1:BURST_W])); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_cap && !advance_n) |=> (mem_addr == $past(addr_in)) && (beat_cnt == '0)); // R8
endmodule

bind burst_addr_unit burst_addr_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr_in        (addr_in),
  .strobe_cache_n (strobe_cache_n),
  .strobe_proc_n  (strobe_proc_n),
  .chip_en_n      (chip_en_n),
  .advance_n      (advance_n),
  .order_sel      (order_sel),
  .mem_addr       (mem_addr),
  .beat_cnt       (beat_cnt)
);

// File: tb/test_burst_addr_unit.sv
`timescale 1ns/1ps
module test_burst_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] addr_in = '0;
  logic        strobe_cache_n = 1'b1;
  logic        strobe_proc_n = 1'b1;
  logic        chip_en_n = 1'b1;
  logic        advance_n = 1'b1;
  logic        order_sel = 1'b0;
  logic [17:0] mem_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [17:0] value;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // bench reference state
  logic [17:0] ref_base = '0;
  int          ref_beat = 0;

  always #2.5 clk = ~clk;

  burst_addr_unit i_burst_addr_unit (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_cache_n(strobe_cache_n), .strobe_proc_n(strobe_proc_n),
    .chip_en_n(chip_en_n), .advance_n(advance_n),
    .order_sel(order_sel), .mem_addr(mem_addr)
  );

  function automatic logic [17:0] predict(logic [17:0] base, int beat, logic ilv);
    int s;
    int lo;
    s = int'(base[1:0]);
    if (ilv) lo = s ^ beat;
    else     lo = (s + beat) % 4;
    return {base[17:2], 2'(lo)};
  endfunction

  task automatic check(logic [17:0] act, logic [17:0] exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: mem_addr actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [17:0] a, logic cs_n, logic ps_n, logic ce_n,
                       logic adv_n, string tag);
    exp_t e;
    @(negedge clk);
    addr_in = a; strobe_cache_n = cs_n; strobe_proc_n = ps_n;
    chip_en_n = ce_n; advance_n = adv_n;
    @(posedge clk);
    #1;
    if (!cs_n || (!ps_n && !ce_n)) begin
      ref_base = a; ref_beat = 0;
    end else if (!adv_n) begin
      ref_beat = (ref_beat + 1) % 4;
    end
    e.value = predict(ref_base, ref_beat, order_sel);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(mem_addr, e.value, e.tag);
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 20000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check(mem_addr, 18'h0, "R9");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cache strobe loads with chip enable deasserted, start 1
    drive(18'h2A5F1, 1'b0, 1'b1, 1'b1, 1'b1, "R1");
    // R5 / R4 / R7: linear 1,2,3,0 then wrap to 1
    for (int i = 0; i < 5; i++) drive(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R5_R7");
    // R3: hold
    drive(18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b1, "R3");
    drive(18'h3FFFF, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
    // R2: processor strobe ignored with chip enable high
    drive(18'h12345, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
    drive(18'h12345, 1'b1, 1'b0, 1'b1, 1'b0, "R2_R4");
    // R2: processor strobe loads with chip enable low
    drive(18'h1C00E, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    drive(18'h00000, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    // R8: load together with advance
    drive(18'h0BEE3, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    drive(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
    drive(18'h3A5A6, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

    // R6: interleaved order, starts 1, 2, 3
    @(negedge clk);
    order_sel = 1'b1;
    for (int s = 1; s < 4; s++) begin
      drive(18'h15550 | 18'(s), 1'b0, 1'b1, 1'b0, 1'b1, "R6");
      for (int k = 0; k < 4; k++) drive(18'h00000, 1'b1, 1'b1, 1'b1, 1'b0, "R6_R7");
    end
    drive(18'h00000, 1'b1, 1'b1, 1'b1, 1'b1, "R3");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule